// File: doc/BRIEF.md
# Auto Crossover Link Sequencer

This block brings up a copper port whose transmit and receive pairs may or may not be crossed. After a start pulse it drives a crossover select output and polls the PHY over a management read port. Each poll waits a programmable number of millisecond ticks and then reads the basic status register. If no link is reported, the select flips between straight (MDI) and crossed (MDIX) wiring and the block polls again. After a bounded number of polls it gives up with a fail flag.

Once link is seen, the block runs a fixed chain of reads. It re-reads the basic status register. If negotiation has completed, it reads the vendor status register and decodes speed and duplex from it. If the local side can negotiate, it then reads the expansion, advertisement and partner-ability registers to decide whether pause flow control applies. The result is packed into an 8-bit port-status image and held with a done flag until the next start.

The management read port is a simple request/acknowledge pair. The request and its PHY address and register number stay fixed until a one-cycle acknowledge returns the read data. How the management frames are serialised is handled elsewhere.

Top module: `mdix_link_seq`

## Requirements
- R1: After reset, no read is requested, the select output is low, and the status image, done flag and fail flag are all zero.
- R2: A start pulse accepted while idle, done or failed clears the results and sets the select low (MDI). Exactly WAIT_MS millisecond ticks later, the block requests register 1 of PHY address PHY_ADDR (default 6).
- R3: When a poll returns bit 2 clear (no link), the select toggles (high = MDIX, low = MDI). A new wait of WAIT_MS ticks follows, and then another poll of register 1.
- R4: After MAX_TRIES polls without link, the fail flag is raised, the done flag stays low, the image stays zero, and no further reads are issued.
- R5: Once a poll shows link, register 1 is read again. If its bit 5 is set, register 31 is read, and only its bits 4:2 are decoded: 1 gives 10 Mb/s half, 5 gives 10 Mb/s full, 2 gives 100 Mb/s half, and 6 gives 100 Mb/s full. Image bit 0 is set for 100 Mb/s and image bit 4 for full duplex. Odd image bits are always zero.
- R6: Any other speed code in bits 4:2 leaves image bits 0 and 4 at zero.
- R7: If the re-read register 1 has bit 3 set, register 6 is read. If its bit 0 is set, register 4 is read. If its bit 10 is set, register 5 is read. Image bit 6 (pause) is set only when register 5 bit 10 is also set. The first test that fails ends the chain, and no later register in it is read.
- R8: If bit 5 of the re-read register 1 is clear, no further register is read, and the image carries only the link bit.
- R9: On success, image bit 2 (link) is set and the done flag goes high. The image and the done flag hold unchanged until the next start.
- R10: A start pulse while a search or read chain is in progress is ignored. It does not reset the select, the wait or the poll count.
- R11: At most one read is outstanding. The request and its register number hold steady until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to begin a link search |
| msTick | input | 1 | One-cycle pulse each millisecond |
| mgmtReq | output | 1 | Management read request, held until acknowledged |
| mgmtPhyAddr | output | 5 | PHY address of the read |
| mgmtRegNum | output | 5 | Register number of the read |
| mgmtAck | input | 1 | One-cycle acknowledge carrying read data |
| mgmtRdData | input | 16 | Read data, valid with mgmtAck |
| xoverSel | output | 1 | Crossover select: 0 = MDI, 1 = MDIX |
| statusImg | output | 8 | Port-status image: bit 0 speed, bit 2 link, bit 4 duplex, bit 6 pause |
| linkDone | output | 1 | Search succeeded, image valid |
| linkFail | output | 1 | Search gave up without link |

## Verification
The link search is exercised with link found on the first, a middle and the last permitted poll, and with link never found. This shows that the select alternation, the tick-exact wait before every poll and the give-up count are independent of one another. The read chain is driven with each defined speed code, with an undecodable code and with noise bits set outside bits 4:2. It is also driven with the chain broken at each of its gates: negotiation incomplete, local negotiation not supported, partner not negotiating, pause not advertised and partner without pause. Comparing the exact list of register reads against the final image separates a wrong decode from a chain that read too far or stopped too early. A stray start pulse in the middle of a wait checks that an active search is not disturbed.

// File: rtl/mdix_pkg.sv
package mdix_pkg;

  localparam int RD_W  = 16;
  localparam int REG_W = 5;

  // management register numbers used by the sequence
  localparam logic [REG_W-1:0] REG_BASIC   = 5'd1;
  localparam logic [REG_W-1:0] REG_ADVERT  = 5'd4;
  localparam logic [REG_W-1:0] REG_PARTNER = 5'd5;
  localparam logic [REG_W-1:0] REG_EXPAND  = 5'd6;
  localparam logic [REG_W-1:0] REG_VSTAT   = 5'd31;

  // status image bit positions
  localparam int IMG_SPEED  = 0;
  localparam int IMG_LINK   = 2;
  localparam int IMG_DUPLEX = 4;
  localparam int IMG_PAUSE  = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_POLL, S_REREAD, S_SPEED,
    S_EXPAND, S_ADVERT, S_PARTNER, S_FINISH, S_DONE, S_FAIL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic runStart;
    logic waitEn;
    logic retry;
    logic capBasic;
    logic capSpeed;
    logic setPause;
    logic commit;
    logic markFail;
  } dpStrobe_t;

endpackage

// File: rtl/mdix_dp.sv
module mdix_dp
  import mdix_pkg::*;
#(
  parameter int WAIT_MS   = 2000,
  parameter int MAX_TRIES = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       msTick,
  input  logic [2:0] rdCode,
  input  logic       rdAnAble,
  output logic       waitDone,
  output logic       lastTry,
  output logic       negCap,
  output logic       xoverSel,
  output logic [7:0] statusImg,
  output logic       linkDone,
  output logic       linkFail
);

  localparam int WC_W = $clog2(WAIT_MS + 1);
  localparam int TC_W = $clog2(MAX_TRIES + 1);
  localparam logic [WC_W-1:0] WAIT_LAST = WC_W'(WAIT_MS - 1);
  localparam logic [TC_W-1:0] TRY_LAST  = TC_W'(MAX_TRIES - 1);

  logic [WC_W-1:0] waitCnt;
  logic [TC_W-1:0] tryCnt;
  logic            isFast;
  logic            isFull;
  logic            hasPause;

  assign waitDone = stb.waitEn && msTick && (waitCnt == WAIT_LAST);
  assign lastTry  = (tryCnt == TRY_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt   <= '0;
      tryCnt    <= '0;
      xoverSel  <= 1'b0;
      isFast    <= 1'b0;
      isFull    <= 1'b0;
      hasPause  <= 1'b0;
      negCap    <= 1'b0;
      statusImg <= '0;
      linkDone  <= 1'b0;
      linkFail  <= 1'b0;
    end else begin
      if (stb.runStart) begin
        waitCnt   <= '0;
        tryCnt    <= '0;
        xoverSel  <= 1'b0;
        isFast    <= 1'b0;
        isFull    <= 1'b0;
        hasPause  <= 1'b0;
        negCap    <= 1'b0;
        statusImg <= '0;
        linkDone  <= 1'b0;
        linkFail  <= 1'b0;
      end
      if (stb.waitEn && msTick)
        waitCnt <= waitDone ? '0 : waitCnt + 1'b1;
      if (stb.retry) begin
        tryCnt   <= tryCnt + 1'b1;
        xoverSel <= ~xoverSel;
        waitCnt  <= '0;
      end
      if (stb.capBasic)
        negCap <= rdAnAble;
      if (stb.capSpeed) begin
        unique case (rdCode)
          3'd1:    begin isFast <= 1'b0; isFull <= 1'b0; end
          3'd5:    begin isFast <= 1'b0; isFull <= 1'b1; end
          3'd2:    begin isFast <= 1'b1; isFull <= 1'b0; end
          3'd6:    begin isFast <= 1'b1; isFull <= 1'b1; end
          default: begin isFast <= 1'b0; isFull <= 1'b0; end
        endcase
      end
      if (stb.setPause)
        hasPause <= 1'b1;
      if (stb.commit) begin
        statusImg             <= '0;
        statusImg[IMG_SPEED]  <= isFast;
        statusImg[IMG_LINK]   <= 1'b1;
        statusImg[IMG_DUPLEX] <= isFull;
        statusImg[IMG_PAUSE]  <= hasPause;
        linkDone              <= 1'b1;
      end
      if (stb.markFail)
        linkFail <= 1'b1;
    end
  end

endmodule

// File: rtl/mdix_ctrl.sv
module mdix_ctrl
  import mdix_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             mgmtAck,
  input  logic             rdLink,
  input  logic             rdAnDone,
  input  logic             rdPartnerAn,
  input  logic             rdPause,
  input  logic             waitDone,
  input  logic             lastTry,
  input  logic             negCap,
  output dpStrobe_t        stb,
  output logic             mgmtReq,
  output logic [REG_W-1:0] mgmtRegNum
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      S_IDLE, S_DONE, S_FAIL: begin
        if (startPulse) begin
          stb.runStart = 1'b1;
          stateNxt     = S_WAIT;
        end
      end
      S_WAIT: begin
        stb.waitEn = 1'b1;
        if (waitDone) stateNxt = S_POLL;
      end
      S_POLL: begin
        if (mgmtAck) begin
          if (rdLink) begin
            stateNxt = S_REREAD;
          end else if (lastTry) begin
            stb.markFail = 1'b1;
            stateNxt     = S_FAIL;
          end else begin
            stb.retry = 1'b1;
            stateNxt  = S_WAIT;
          end
        end
      end
      S_REREAD: begin
        if (mgmtAck) begin
          stb.capBasic = 1'b1;
          stateNxt     = rdAnDone ? S_SPEED : S_FINISH;
        end
      end
      S_SPEED: begin
        if (mgmtAck) begin
          stb.capSpeed = 1'b1;
          stateNxt     = negCap ? S_EXPAND : S_FINISH;
        end
      end
      S_EXPAND: if (mgmtAck) stateNxt = rdPartnerAn ? S_ADVERT : S_FINISH;
      S_ADVERT: if (mgmtAck) stateNxt = rdPause ? S_PARTNER : S_FINISH;
      S_PARTNER: begin
        if (mgmtAck) begin
          stb.setPause = rdPause;
          stateNxt     = S_FINISH;
        end
      end
      S_FINISH: begin
        stb.commit = 1'b1;
        stateNxt   = S_DONE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_comb begin
    mgmtReq    = 1'b1;
    mgmtRegNum = REG_BASIC;
    unique case (state)
      S_POLL, S_REREAD: mgmtRegNum = REG_BASIC;
      S_SPEED:          mgmtRegNum = REG_VSTAT;
      S_EXPAND:         mgmtRegNum = REG_EXPAND;
      S_ADVERT:         mgmtRegNum = REG_ADVERT;
      S_PARTNER:        mgmtRegNum = REG_PARTNER;
      default:          mgmtReq    = 1'b0;
    endcase
  end

endmodule

// File: rtl/mdix_link_seq.sv
module mdix_link_seq
  import mdix_pkg::*;
#(
  parameter int          WAIT_MS   = 2000,
  parameter int          MAX_TRIES = 100,
  parameter logic [4:0]  PHY_ADDR  = 5'd6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        msTick,
  output logic        mgmtReq,
  output logic [4:0]  mgmtPhyAddr,
  output logic [4:0]  mgmtRegNum,
  input  logic        mgmtAck,
  input  logic [15:0] mgmtRdData,
  output logic        xoverSel,
  output logic [7:0]  statusImg,
  output logic        linkDone,
  output logic        linkFail
);

  dpStrobe_t stb;
  logic      waitDone;
  logic      lastTry;
  logic      negCap;
  logic      unusedRdBits;

  assign mgmtPhyAddr  = PHY_ADDR;
  assign unusedRdBits = ^{mgmtRdData[15:11], mgmtRdData[9:6], mgmtRdData[1]};

  mdix_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .mgmtAck     (mgmtAck),
    .rdLink      (mgmtRdData[2]),
    .rdAnDone    (mgmtRdData[5]),
    .rdPartnerAn (mgmtRdData[0]),
    .rdPause     (mgmtRdData[10]),
    .waitDone    (waitDone),
    .lastTry     (lastTry),
    .negCap      (negCap),
    .stb         (stb),
    .mgmtReq     (mgmtReq),
    .mgmtRegNum  (mgmtRegNum)
  );

  mdix_dp #(
    .WAIT_MS   (WAIT_MS),
    .MAX_TRIES (MAX_TRIES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .msTick    (msTick),
    .rdCode    (mgmtRdData[4:2]),
    .rdAnAble  (mgmtRdData[3]),
    .waitDone  (waitDone),
    .lastTry   (lastTry),
    .negCap    (negCap),
    .xoverSel  (xoverSel),
    .statusImg (statusImg),
    .linkDone  (linkDone),
    .linkFail  (linkFail)
  );

endmodule

// File: rtl/mdix_link_seq_chk.sv
module mdix_link_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic       mgmtReq,
  input logic       mgmtAck,
  input logic [4:0] mgmtRegNum,
  input logic       xoverSel,
  input logic [7:0] statusImg,
  input logic       linkDone,
  input logic       linkFail
);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    mgmtReq && !mgmtAck |=> mgmtReq && $stable(mgmtRegNum));

  p_fail_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    linkFail |-> !mgmtReq && statusImg == 8'h00);

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(linkDone && linkFail));

  p_done_link_r9: assert property (@(posedge clk) disable iff (!rstN)
    linkDone |-> statusImg[2] && !mgmtReq);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    linkDone && !startPulse |=> linkDone && $stable(statusImg));

  p_img_spare_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusImg & 8'hAA) == 8'h00);

  p_sel_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(xoverSel) |-> $past(mgmtAck) || $past(startPulse));

endmodule

bind mdix_link_seq mdix_link_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .mgmtReq    (mgmtReq),
  .mgmtAck    (mgmtAck),
  .mgmtRegNum (mgmtRegNum),
  .xoverSel   (xoverSel),
  .statusImg  (statusImg),
  .linkDone   (linkDone),
  .linkFail   (linkFail)
);

// File: tb/mdix_link_seq_bench.sv
module mdix_link_seq_bench;

  localparam int WAIT_MS   = 3;
  localparam int MAX_TRIES = 4;
  localparam int PHY       = 6;

  typedef struct {
    int regNum;
    int sel;
    bit isPoll;
  } expRd_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        msTick = 1'b0;
  logic        mgmtAck = 1'b0;
  logic [15:0] mgmtRdData = '0;
  logic        mgmtReq;
  logic [4:0]  mgmtPhyAddr;
  logic [4:0]  mgmtRegNum;
  logic        xoverSel;
  logic [7:0]  statusImg;
  logic        linkDone;
  logic        linkFail;

  mdix_link_seq #(
    .WAIT_MS   (WAIT_MS),
    .MAX_TRIES (MAX_TRIES),
    .PHY_ADDR  (5'(PHY))
  ) u_mdix_link_seq (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .msTick      (msTick),
    .mgmtReq     (mgmtReq),
    .mgmtPhyAddr (mgmtPhyAddr),
    .mgmtRegNum  (mgmtRegNum),
    .mgmtAck     (mgmtAck),
    .mgmtRdData  (mgmtRdData),
    .xoverSel    (xoverSel),
    .statusImg   (statusImg),
    .linkDone    (linkDone),
    .linkFail    (linkFail)
  );

  always #2 clk = ~clk;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  expRd_t expQ[$];
  int  expImg;
  bit  expFail;
  bit  running = 0;
  bit  acceptStart = 0;
  bit  caseOver = 0;
  int  tickCnt = 0;
  bit  pending = 0;
  bit  ackNow = 0;
  int  ackDelay = 0;
  int  curReg = 0;
  int  reg1Reads = 0;
  logic prevDone = 1'b0;
  logic prevFail = 1'b0;

  // responder configuration
  int          cfgLinkAt;
  logic [15:0] cfgBasic, cfgExp, cfgAdv, cfgLpa;
  int          cfgCode;

  task automatic chk(bit ok, string rq, int act, int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] reply(int rn);
    logic [15:0] d;
    d = '0;
    case (rn)
      1: begin
        if (cfgLinkAt < 0 || reg1Reads <= cfgLinkAt)
          d = (reg1Reads == cfgLinkAt) ? 16'h0004 : 16'h0000;
        else
          d = cfgBasic;
        reg1Reads++;
      end
      31: d = 16'h8001 | 16'(cfgCode << 2);
      6:  d = cfgExp;
      4:  d = cfgAdv;
      5:  d = cfgLpa;
      default: d = '0;
    endcase
    return d;
  endfunction

  // tick source
  initial begin
    forever begin
      repeat (4) @(negedge clk);
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
    end
  end

  // monitor and management responder
  always @(negedge clk) begin
    #1;
    if (ackNow) begin
      ackNow  = 0;
      mgmtAck = 1'b0;
      pending = 0;
    end
    if (startPulse && acceptStart) tickCnt = 0;
    else if (running && !mgmtReq && msTick) tickCnt++;

    if (mgmtReq && !pending) begin
      pending  = 1;
      ackDelay = 2;
      curReg   = int'(mgmtRegNum);
      if (expQ.size() == 0) begin
        chk(0, "R4/R8 unexpected read", int'(mgmtRegNum), -1);
      end else begin
        expRd_t e;
        e = expQ.pop_front();
        chk(int'(mgmtRegNum) == e.regNum, "R5/R7 register order", int'(mgmtRegNum), e.regNum);
        chk(int'(mgmtPhyAddr) == PHY, "R2 phy address", int'(mgmtPhyAddr), PHY);
        chk(int'(xoverSel) == e.sel, "R3 crossover select", int'(xoverSel), e.sel);
        if (e.isPoll)
          chk(tickCnt == WAIT_MS, "R2 wait ticks before poll", tickCnt, WAIT_MS);
      end
      tickCnt = 0;
    end else if (pending) begin
      if (!mgmtReq || int'(mgmtRegNum) != curReg)
        chk(0, "R11 request held", int'(mgmtRegNum), curReg);
      if (ackDelay == 0) begin
        mgmtRdData = reply(curReg);
        mgmtAck    = 1'b1;
        ackNow     = 1;
      end else begin
        ackDelay--;
      end
    end

    if (running && ((linkDone && !prevDone) || (linkFail && !prevFail))) begin
      chk(expQ.size() == 0, "R7 reads left over", expQ.size(), 0);
      chk(int'(statusImg) == expImg, "R5 status image", int'(statusImg), expImg);
      chk(linkFail == expFail, "R4 fail flag", int'(linkFail), int'(expFail));
      chk(linkDone == !expFail, "R9 done flag", int'(linkDone), int'(!expFail));
      running  = 0;
      caseOver = 1;
    end
    prevDone = linkDone;
    prevFail = linkFail;
  end

  task automatic runCase(string nm, int linkAt, logic [15:0] basic, int code,
                         logic [15:0] ex, logic [15:0] adv, logic [15:0] lpa, bit poke);
    int img;
    int nPolls;
    cfgLinkAt = linkAt; cfgBasic = basic | 16'h0004; cfgCode = code;
    cfgExp = ex; cfgAdv = adv; cfgLpa = lpa;
    reg1Reads = 0;
    expQ.delete();
    nPolls = (linkAt < 0) ? MAX_TRIES : linkAt + 1;
    for (int p = 0; p < nPolls; p++) expQ.push_back('{1, p % 2, 1'b1});
    img = 0;
    if (linkAt >= 0) begin
      img = 4;
      expQ.push_back('{1, linkAt % 2, 1'b0});
      if (basic[5]) begin
        expQ.push_back('{31, linkAt % 2, 1'b0});
        case (code)
          1: img = img;
          5: img = img | 16;
          2: img = img | 1;
          6: img = img | 17;
          default: img = img;
        endcase
        if (basic[3]) begin
          expQ.push_back('{6, linkAt % 2, 1'b0});
          if (ex[0]) begin
            expQ.push_back('{4, linkAt % 2, 1'b0});
            if (adv[10]) begin
              expQ.push_back('{5, linkAt % 2, 1'b0});
              if (lpa[10]) img = img | 64;
            end
          end
        end
      end
    end
    expFail = (linkAt < 0);
    expImg  = img;
    $display("[TB] case %s", nm);

    @(negedge clk);
    acceptStart = 1; startPulse = 1'b1; running = 1; caseOver = 0;
    @(negedge clk);
    startPulse = 1'b0; acceptStart = 0;

    if (poke) begin
      // R10: stray start during the second wait
      wait (reg1Reads >= 1 && !pending);
      repeat (3) @(negedge clk);
      startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end

    wait (caseOver);
    repeat (20) @(negedge clk);
    #1;
    chk(int'(statusImg) == expImg, "R9 image held", int'(statusImg), expImg);
    chk(linkDone == !expFail, "R9 done held", int'(linkDone), int'(!expFail));
    chk(!mgmtReq, "R4 idle after finish", int'(mgmtReq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!mgmtReq, "R1 reset request", int'(mgmtReq), 0);
    chk(!xoverSel, "R1 reset select", int'(xoverSel), 0);
    chk(statusImg == 8'h00, "R1 reset image", int'(statusImg), 0);
    chk(!linkDone && !linkFail, "R1 reset flags", int'({linkDone, linkFail}), 0);

    // full chain, 100 full with pause, link on third poll, stray start (R10)
    runCase("full_pause", 2, 16'h0028, 6, 16'h0001, 16'h0400, 16'h0400, 1);
    // no negotiation ability, 10 half (R5)
    runCase("ten_half", 0, 16'h0020, 1, 16'h0001, 16'h0400, 16'h0400, 0);
    // partner lacks pause, 10 full (R7)
    runCase("ten_full_nopause", 1, 16'h0028, 5, 16'h0001, 16'h0400, 16'h0000, 0);
    // partner not negotiating, 100 half, link on last poll (R7, R3)
    runCase("fast_half", MAX_TRIES - 1, 16'h0028, 2, 16'h0000, 16'h0400, 16'h0400, 0);
    // no link at all (R4)
    runCase("no_link", -1, 16'h0000, 0, 16'h0000, 16'h0000, 16'h0000, 0);
    // negotiation incomplete (R8)
    runCase("not_complete", 0, 16'h0008, 6, 16'h0001, 16'h0400, 16'h0400, 0);
    // undecoded code, pause not advertised (R6, R7)
    runCase("bad_code", 1, 16'h0028, 3, 16'h0001, 16'h0000, 16'h0400, 0);
    // code 7 also undecoded (R6)
    runCase("code_seven", 0, 16'h0020, 7, 16'h0000, 16'h0000, 16'h0000, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule